// File: doc/BRIEF.md
# Transform Vector Framing Synchronizer

This block decides which input sample opens each data vector handed to a block transform engine. Software first arms it. The block then waits for an external timing tick and marks the first valid sample after that tick with a one-sample vector-start flag. After that it free-runs, flagging every 2^L-th valid sample, until a stop request ends framing cleanly at a vector boundary.

A half-offset control bit lets two identical units, fed with the same sample stream and the same tick, produce transforms that overlap by half a vector. The unit with the bit set holds back its first vector-start by 2^(L-1) valid samples. The transform length is given as a base-2 logarithm and is captured when framing starts, so it stays fixed for the whole run. The sample datapath does not pass through this block; it only observes the sample-valid strobe.

Top module: `vector_sync`

## Requirements
- R1: After reset the unit is idle: `vec_start_o`, `active_o` and `lead_o` are 0 and `pos_o` is 0.
- R2: After an arm request (`arm_i` high for one cycle) and then a tick event, `active_o` rises in the cycle after the tick is sampled. Without half offset, the first valid sample from that cycle onward carries `vec_start_o`.
- R3: A tick event has no effect while the unit is idle and unarmed, and none while framing is active: the vector-start spacing stays unchanged.
- R4: While active, `vec_start_o` is high only in a cycle with `smp_vld_i` high, and on every 2^L-th valid sample. Cycles with `smp_vld_i` low do not advance the count.
- R5: With `half_ofs_i` high when framing starts, the first `vec_start_o` comes on the valid sample with index 2^(L-1) counted from 0, and `lead_o` is high until then. `lead_o` is never high together with `vec_start_o`.
- R6: A stop request while active takes effect at the end of the current vector. `active_o` falls in the cycle after the last valid sample of that vector, so no partial vector is ever flagged.
- R7: A stop request while armed returns the unit to idle at once, so a later tick starts nothing. If arm and stop are both high in the same idle cycle, stop wins.
- R8: `len_log2_i` is captured when framing starts. Changes to it while active do not alter the vector-start spacing.
- R9: A `len_log2_i` value below MIN_LOG2 or above MAX_LOG2 is clamped to that limit (with defaults: 0 gives length 2, 15 gives length 256).
- R10: While active, `pos_o` gives the index of the current sample within its vector (0 at a vector start). It advances by one on each valid sample, wraps after 2^L-1, and holds when `smp_vld_i` is low. During the lead phase it starts at 2^(L-1).
- R11: With TICK_EDGE=1 (the default) a tick event is a rising edge of `tick_i`: a tick held high across arming starts nothing until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 1 | Sample-valid strobe of the input stream |
| tick_i | input | 1 | External timing tick |
| arm_i | input | 1 | Arm request, one cycle |
| stop_i | input | 1 | Stop request, one cycle |
| half_ofs_i | input | 1 | Half-vector start offset, captured at start |
| len_log2_i | input | LW (4) | Transform length as log2, captured at start |
| vec_start_o | output | 1 | Marks the first sample of a vector (qualified by the current strobe) |
| active_o | output | 1 | Framing running |
| lead_o | output | 1 | Half-offset lead phase, no vector yet |
| pos_o | output | CW (8) | Sample index within the vector |

## Verification
The bench builds the block with its defaults: MIN_LOG2=1, MAX_LOG2=8, rising-edge tick detection. Lengths from 2 to the full 256 samples are therefore available, and the clamping at both ends of the 4-bit length field can be driven. The 256-sample case makes the counter use all eight bits and wrap from 255. Short lengths keep the stop-at-boundary, lead-phase and random-gap runs within a few hundred cycles. Edge detection makes the held-high tick case observable.

// File: rtl/vsync_pkg.sv
package vsync_pkg;

   typedef enum logic [1:0] {
      FR_IDLE  = 2'd0,
      FR_ARMED = 2'd1,
      FR_RUN   = 2'd2
   } fr_state_t;

   function automatic int unsigned clamp_log2(input int unsigned v,
                                              input int unsigned lo,
                                              input int unsigned hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

endpackage

// File: rtl/vsync_tick_detect.sv
module vsync_tick_detect #(
   parameter bit TICK_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic evt_o
);

   generate
      if (TICK_EDGE) begin : g_edge
         logic tick_q;
         always_ff @(posedge clk) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= tick_i;
         end
         assign evt_o = tick_i & ~tick_q;
      end else begin : g_level
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign evt_o     = tick_i;
      end
   endgenerate

endmodule

// File: rtl/vsync_len_cfg.sv
module vsync_len_cfg
   import vsync_pkg::*;
#(
   parameter int MIN_LOG2 = 1,
   parameter int MAX_LOG2 = 8,
   parameter int LW       = 4,
   parameter int CW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [LW-1:0] len_log2_i,
   output logic [CW-1:0] half_next_o,
   output logic [CW-1:0] last_idx_o
);

   logic [LW-1:0] len_c;
   logic [LW-1:0] len_q;

   always_comb begin
      len_c       = LW'(clamp_log2(int'(len_log2_i), MIN_LOG2, MAX_LOG2));
      half_next_o = CW'(32'd1 << (int'(len_c) - 1));
      last_idx_o  = CW'((32'd1 << int'(len_q)) - 32'd1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      len_q <= LW'(MIN_LOG2);
      else if (load_i) len_q <= len_c;
   end

endmodule

// File: rtl/vsync_frame_cnt.sv
module vsync_frame_cnt #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic          adv_i,
   input  logic [CW-1:0] last_idx_i,
   output logic [CW-1:0] cnt_o,
   output logic          wrap_o,
   output logic          first_o
);

   logic [CW-1:0] cnt_q;

   assign wrap_o  = adv_i && (cnt_q == last_idx_i);
   assign first_o = (cnt_q == '0);
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (adv_i)  cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/vsync_ctrl.sv
module vsync_ctrl
   import vsync_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic stop_i,
   input  logic tick_evt_i,
   input  logic half_ofs_i,
   input  logic wrap_i,
   output logic start_o,
   output logic run_o,
   output logic lead_o
);

   fr_state_t st_q, st_d;
   logic      stop_pend_q;
   logic      lead_q;

   always_comb begin
      st_d    = st_q;
      start_o = 1'b0;
      unique case (st_q)
         FR_IDLE:  if (arm_i && !stop_i) st_d = FR_ARMED;
         FR_ARMED: begin
            if (stop_i)          st_d = FR_IDLE;
            else if (tick_evt_i) begin
               st_d    = FR_RUN;
               start_o = 1'b1;
            end
         end
         FR_RUN:   if (wrap_i && (stop_i || stop_pend_q)) st_d = FR_IDLE;
         default:  st_d = FR_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= FR_IDLE;
         stop_pend_q <= 1'b0;
         lead_q      <= 1'b0;
      end else begin
         st_q        <= st_d;
         stop_pend_q <= (st_q == FR_RUN && st_d == FR_RUN) ? (stop_pend_q | stop_i) : 1'b0;
         if (start_o)     lead_q <= half_ofs_i;
         else if (wrap_i) lead_q <= 1'b0;
      end
   end

   assign run_o  = (st_q == FR_RUN);
   assign lead_o = lead_q & run_o;

endmodule

// File: rtl/vector_sync.sv
module vector_sync
   import vsync_pkg::*;
#(
   parameter int   MIN_LOG2  = 1,
   parameter int   MAX_LOG2  = 8,
   parameter bit   TICK_EDGE = 1'b1,
   localparam int  CW        = MAX_LOG2,
   localparam int  LW        = $clog2(MAX_LOG2 + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_vld_i,
   input  logic          tick_i,
   input  logic          arm_i,
   input  logic          stop_i,
   input  logic          half_ofs_i,
   input  logic [LW-1:0] len_log2_i,
   output logic          vec_start_o,
   output logic          active_o,
   output logic          lead_o,
   output logic [CW-1:0] pos_o
);

   generate
      if (MIN_LOG2 < 1) begin : g_bad_min
         $error("vector_sync: MIN_LOG2 must be at least 1");
      end
      if (MAX_LOG2 < MIN_LOG2) begin : g_bad_range
         $error("vector_sync: MAX_LOG2 below MIN_LOG2");
      end
      if (MAX_LOG2 > 16) begin : g_bad_max
         $error("vector_sync: MAX_LOG2 above 16");
      end
   endgenerate

   logic          tick_evt;
   logic          start;
   logic          run;
   logic          wrap;
   logic          first;
   logic [CW-1:0] half_next;
   logic [CW-1:0] last_idx;
   logic [CW-1:0] cnt;
   logic [CW-1:0] load_val;
   logic          adv;

   vsync_tick_detect #(.TICK_EDGE(TICK_EDGE)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .evt_o  (tick_evt)
   );

   vsync_len_cfg #(
      .MIN_LOG2 (MIN_LOG2),
      .MAX_LOG2 (MAX_LOG2),
      .LW       (LW),
      .CW       (CW)
   ) u_len (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (start),
      .len_log2_i  (len_log2_i),
      .half_next_o (half_next),
      .last_idx_o  (last_idx)
   );

   assign load_val = half_ofs_i ? half_next : '0;
   assign adv      = run & smp_vld_i;

   vsync_frame_cnt #(.CW(CW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (start),
      .load_val_i (load_val),
      .adv_i      (adv),
      .last_idx_i (last_idx),
      .cnt_o      (cnt),
      .wrap_o     (wrap),
      .first_o    (first)
   );

   vsync_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (arm_i),
      .stop_i     (stop_i),
      .tick_evt_i (tick_evt),
      .half_ofs_i (half_ofs_i),
      .wrap_i     (wrap),
      .start_o    (start),
      .run_o      (run),
      .lead_o     (lead_o)
   );

   assign vec_start_o = adv & first;
   assign active_o    = run;
   assign pos_o       = cnt;

endmodule

// File: rtl/vector_sync_chk.sv
module vector_sync_chk #(
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_vld,
   input logic          vec_start,
   input logic          active,
   input logic          lead,
   input logic [CW-1:0] pos,
   input logic [CW-1:0] last_idx
);

   // R4
   vs_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_start |-> (smp_vld && active));

   // R5
   lead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lead |-> !vec_start);

   // R6
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !(smp_vld && pos == last_idx)) |=> active);

   // R10
   pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !smp_vld) |=> (pos == $past(pos)));

   // R10
   pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && smp_vld && pos != last_idx) |=> (pos == CW'($past(pos) + 1'b1)));

   // R8
   len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(last_idx));

endmodule

bind vector_sync vector_sync_chk #(.CW(CW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_vld   (smp_vld_i),
   .vec_start (vec_start_o),
   .active    (active_o),
   .lead      (lead_o),
   .pos       (pos_o),
   .last_idx  (last_idx)
);

// File: tb/vector_sync_tb_top.sv
`timescale 1ns/1ps
module vector_sync_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       smp_vld, tick, arm, stop, half_ofs;
   logic [3:0] len_log2;
   logic       vec_start, active, lead;
   logic [7:0] pos;

   int n_chk = 0;
   int n_err = 0;
   int vs_cnt = 0;
   int cyc_cnt = 0;
   bit done = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   vector_sync dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_vld_i   (smp_vld),
      .tick_i      (tick),
      .arm_i       (arm),
      .stop_i      (stop),
      .half_ofs_i  (half_ofs),
      .len_log2_i  (len_log2),
      .vec_start_o (vec_start),
      .active_o    (active),
      .lead_o      (lead),
      .pos_o       (pos)
   );

   // behavioural reference: 0 idle, 1 armed, 2 running
   int m_st, m_n, m_off, m_len;
   bit m_stop, m_tp;

   function automatic int lg_clamp(input int v);
      if (v < 1) return 1;
      if (v > 8) return 8;
      return v;
   endfunction

   always @(posedge clk) begin
      bit evt;
      cyc_cnt++;
      if (!rst_n) begin
         m_st = 0; m_n = 0; m_off = 0; m_len = 2; m_stop = 0; m_tp = 0;
      end else begin
         evt  = tick && !m_tp;
         m_tp = tick;
         case (m_st)
            0: if (arm && !stop) m_st = 1;
            1: if (stop) m_st = 0;
               else if (evt) begin
                  m_len  = 1 << lg_clamp(int'(len_log2));
                  m_off  = half_ofs ? m_len / 2 : 0;
                  m_n    = 0;
                  m_stop = 0;
                  m_st   = 2;
               end
            default: begin
               if (smp_vld) begin
                  if (((m_n + m_off) % m_len) == m_len - 1 && (stop || m_stop)) m_st = 0;
                  m_n++;
               end
               if (stop) m_stop = 1;
            end
         endcase
      end
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      bit e_act, e_vs, e_lead;
      int e_pos;
      if (rst_n && !done) begin
         e_act  = (m_st == 2);
         e_pos  = e_act ? (m_n + m_off) % m_len : 0;
         e_vs   = e_act && smp_vld && e_pos == 0;
         e_lead = e_act && m_off != 0 && m_n < m_len - m_off;
         chk({cur_req, " R6"}, "active_o", active, e_act);
         chk({cur_req, " R4"}, "vec_start_o", vec_start, e_vs);
         chk({cur_req, " R5"}, "lead_o", lead, e_lead);
         if (e_act) chk({cur_req, " R10"}, "pos_o", pos, e_pos);
         if (vec_start) vs_cnt++;
      end
   end

   task automatic cyc(); @(posedge clk); #1; endtask
   task automatic cycn(input int n); for (int i = 0; i < n; i++) cyc(); endtask

   task automatic start_run(input int lg, input bit h);
      len_log2 = 4'(lg); half_ofs = h; smp_vld = 1'b1;
      arm = 1'b1; cyc(); arm = 1'b0;
      tick = 1'b1; cyc(); tick = 1'b0;
   endtask

   task automatic drain();
      stop = 1'b1; cyc(); stop = 1'b0;
      smp_vld = 1'b1;
      for (int i = 0; i < 600 && active; i++) cyc();
      cycn(2);
   endtask

   initial begin
      int c0;
      rst_n = 1'b0; smp_vld = 0; tick = 0; arm = 0; stop = 0; half_ofs = 0; len_log2 = 4'd2;
      cycn(3);
      cur_req = "R1";
      chk("R1", "vec_start_o", vec_start, 0);
      chk("R1", "active_o", active, 0);
      chk("R1", "lead_o", lead, 0);
      chk("R1", "pos_o", pos, 0);
      rst_n = 1'b1; cyc();

      // R2: first valid sample after tick is flagged
      cur_req = "R2";
      start_run(2, 0);
      chk("R2", "active_o after tick", active, 1);
      chk("R2", "vec_start_o on first sample", vec_start, 1);
      c0 = vs_cnt; cycn(12);
      chk("R2", "vector count over 12 samples", vs_cnt - c0, 3);
      drain();

      // R3: tick while idle unarmed, and while running
      cur_req = "R3";
      tick = 1; cyc(); tick = 0; cycn(3);
      chk("R3", "active_o after unarmed tick", active, 0);
      start_run(2, 0);
      c0 = vs_cnt;
      for (int i = 0; i < 16; i++) begin tick = (i % 5 == 2); cyc(); end
      tick = 0;
      chk("R3", "vector count with ticks while running", vs_cnt - c0, 4);
      drain();

      // R4: gaps in the valid strobe
      cur_req = "R4";
      start_run(3, 0);
      c0 = vs_cnt; smp_vld = 0; cycn(5);
      chk("R4", "no vector on invalid cycles", vs_cnt - c0, 0);
      chk("R10", "pos held during gap", pos, 0);
      for (int i = 0; i < 150; i++) begin smp_vld = ($urandom % 3) != 0; cyc(); end
      drain();

      // R5: half offset
      cur_req = "R5";
      start_run(3, 1);
      chk("R5", "lead_o at start", lead, 1);
      chk("R10", "pos at start of lead", pos, 4);
      c0 = vs_cnt; cycn(4);
      chk("R5", "no vector during lead", vs_cnt - c0, 0);
      chk("R5", "vec_start_o after half length", vec_start, 1);
      for (int i = 0; i < 60; i++) begin smp_vld = ($urandom % 2) != 0; cyc(); end
      drain();

      // R6: stop at vector boundary
      cur_req = "R6";
      start_run(3, 0);
      c0 = vs_cnt; cyc();
      stop = 1; cyc(); stop = 0;
      cycn(5);
      chk("R6", "still active on last sample", active, 1);
      chk("R6", "pos of last sample", pos, 7);
      cyc();
      chk("R6", "idle after boundary", active, 0);
      cycn(10);
      chk("R6", "no vector after stop", vs_cnt - c0, 1);

      // R7: stop beats arm; stop while armed
      cur_req = "R7";
      arm = 1; stop = 1; cyc(); arm = 0; stop = 0;
      tick = 1; cyc(); tick = 0; cycn(2);
      chk("R7", "arm+stop leaves idle", active, 0);
      arm = 1; cyc(); arm = 0; stop = 1; cyc(); stop = 0;
      tick = 1; cyc(); tick = 0; cycn(2);
      chk("R7", "stop while armed", active, 0);

      // R8: length captured at start
      cur_req = "R8";
      start_run(2, 0);
      c0 = vs_cnt; len_log2 = 4'd3; cycn(16);
      chk("R8", "spacing kept after length change", vs_cnt - c0, 4);
      drain();

      // R9: clamping
      cur_req = "R9";
      start_run(0, 0);
      c0 = vs_cnt; cycn(8);
      chk("R9", "length 0 clamps to 2", vs_cnt - c0, 4);
      drain();
      start_run(15, 0);
      c0 = vs_cnt; cycn(512);
      chk("R9", "length 15 clamps to 256", vs_cnt - c0, 2);
      drain();

      // R11: tick held high across arming
      cur_req = "R11";
      tick = 1; cycn(2);
      arm = 1; cyc(); arm = 0; cycn(3);
      chk("R11", "held tick starts nothing", active, 0);
      tick = 0; cyc(); tick = 1; cyc(); tick = 0;
      chk("R11", "new rising edge starts", active, 1);
      drain();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      wait (cyc_cnt > 20000);
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc_cnt);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule